// File: doc/BRIEF.md
# LCD Line Scan and Frame Timing Generator

This block runs the refresh of a dot-matrix liquid crystal panel from a display RAM that holds one 80-bit row per line. Each pulse of the line clock moves a row counter to the next line, and the common output for that line becomes active. On the same clock edge the segment outputs take on the RAM row for that line. The row address is the line number plus a programmable start-line offset, modulo the RAM depth, so the image scrolls by rewriting one register. The block fetches each row one line ahead through a synchronous RAM read port. This lets the segment pattern and the common select change on the same edge.

Control inputs come from the command decoder. They select 1/16 or 1/32 duty, a reversed column-to-segment mapping, display on or off, and static drive. Static drive while the display is off puts the block into power save. The frame AC signal (FR) is shared between chips. A master toggles it once per frame and drives it out. A slave takes FR as an input and uses each edge to realign its row counter to the master's frame start. The analog bias levels are not part of this block.

Top module: `lcd_scan_timing`

## Requirements
- R1: After reset, com_sel and seg_data are all zero and fr_out is 0. No line is shown until the first line_tick.
- R2: The first line_tick after reset shows line 0. Each later line_tick shows the next line. The count wraps to 0 after line 15 when duty_full=0, and after line 31 when duty_full=1. Line n is shown as com_sel with only bit n set.
- R3: With duty_full=1, lines 16 to 31 are scanned but drive no common output, so com_sel is all zero for those lines.
- R4: ram_rd_addr is (start_line + the line to be shown at the next tick) mod 32. The RAM returns data one clock after the address. At each tick, seg_data takes the row read from that address.
- R5: With seg_reverse=0, seg_data[i] is row bit i. With seg_reverse=1, seg_data[i] is row bit 79-i.
- R6: With disp_on=0 and static_drive=0, seg_data is set to all zero at each tick, whatever the RAM holds, while com_sel keeps scanning.
- R7: With disp_on=1 and static_drive=1, seg_data is set to all ones at each tick, while com_sel keeps scanning.
- R8: disp_on=0 with static_drive=1 sets power_save=1. Ticks then set com_sel and seg_data to zero, and the line count holds. When power save ends, the next tick shows the line after the last one scanned.
- R9: When master=1, fr_oe=1, and fr_out toggles on every tick that moves the scan to line 0, and at no other time.
- R10: When master=0, fr_oe=0, and fr_out follows fr_in one clock later. A change on fr_in sets the row counter to line 0, so the next tick shows line 1.
- R11: seg_data and com_sel change only on the clock edge where line_tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle line clock pulse |
| master | input | 1 | 1: generate FR, 0: follow fr_in |
| fr_in | input | 1 | FR from the master chip (slave mode) |
| disp_on | input | 1 | 1: display shown, 0: blanked |
| static_drive | input | 1 | Static drive select |
| duty_full | input | 1 | 0: 16-line frame, 1: 32-line frame |
| seg_reverse | input | 1 | Reverse column-to-segment order |
| start_line | input | 5 | RAM line shown on common 0 |
| ram_rd_addr | output | 5 | Display RAM row address |
| ram_rd_data | input | 80 | Row returned by the RAM, one clock after the address |
| seg_data | output | 80 | Latched segment pattern |
| com_sel | output | 16 | One-hot common select |
| fr_out | output | 1 | Frame AC signal in use by this chip |
| fr_oe | output | 1 | Output enable for FR (master only) |
| power_save | output | 1 | Power-save state indicator |

## Verification
The one-line prefetch works only if line_tick pulses have at least one idle clock between them. start_line, duty_full and the mode inputs must also be settled for two clocks before a tick. Without that, the RAM word the block latches could belong to an earlier address, and the properties on address and row content would be meaningless. The assertions also rely on fr_in being held steady in master mode and toggling only between ticks in slave mode. Every scenario task in the bench changes configuration only through a helper that waits two clocks afterwards. Ticks are sent as single-cycle pulses separated by idle cycles.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  // What the segment latch loads at a tick
  typedef enum logic [1:0] {
    ROW_PASS  = 2'd0,  // RAM row, optionally mirrored
    ROW_BLANK = 2'd1,  // all segments off
    ROW_FULL  = 2'd2   // all segments on (static drive, display on)
  } row_mode_e;

  function automatic row_mode_e pick_row_mode(input logic disp_on, input logic static_drive);
    if (!disp_on)     return ROW_BLANK;
    if (static_drive) return ROW_FULL;
    return ROW_PASS;
  endfunction

  function automatic logic is_power_save(input logic disp_on, input logic static_drive);
    return !disp_on && static_drive;
  endfunction

endpackage

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr #(
  parameter int NUM_LINES = 32,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              hold,
  input  logic              duty_full,
  input  logic              resync,
  output logic [LINE_W-1:0] cur_line,
  output logic [LINE_W-1:0] next_line,
  output logic              wrap_evt
);
  localparam int HALF_LINES = NUM_LINES / 2;

  // Successor of a line within the selected frame length
  function automatic logic [LINE_W-1:0] step_line(input logic [LINE_W-1:0] cur, input logic full);
    int limit;
    limit = full ? NUM_LINES : HALF_LINES;
    if (int'(cur) >= limit - 1) return '0;
    return cur + 1'b1;
  endfunction

  logic primed;
  logic advance;

  assign next_line = primed ? step_line(cur_line, duty_full) : '0;
  assign advance   = line_tick && !hold;
  assign wrap_evt  = advance && (next_line == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_line <= '0;
      primed   <= 1'b0;
    end else if (resync) begin
      cur_line <= '0;
      primed   <= 1'b1;
    end else if (advance) begin
      cur_line <= next_line;
      primed   <= 1'b1;
    end
  end

  // R2: a tick moves the line by one or restarts at 0
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !resync) |=> (cur_line == '0) || (cur_line == $past(cur_line) + 1'b1));

  // R8: in power save the line position is frozen
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && hold && !resync) |=> $stable(cur_line));

  // R10: a slave realignment lands on line 0
  a_r10_resync: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> cur_line == '0);

endmodule

// File: rtl/lcd_frame_ac.sv
module lcd_frame_ac (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic fr_in,
  input  logic wrap_evt,
  output logic fr_q,
  output logic resync
);
  // A slave sees an FR edge as a difference between the pin and its copy
  assign resync = !master && (fr_in != fr_q);

  always_ff @(posedge clk) begin
    if (!rst_n)        fr_q <= 1'b0;
    else if (master) begin
      if (wrap_evt)    fr_q <= ~fr_q;
    end else           fr_q <= fr_in;
  end

  // R9: the master keeps FR steady except at a frame start
  a_r9_fr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !wrap_evt) |=> $stable(fr_q));

  // R10: a slave copies the incoming FR one clock later
  a_r10_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> fr_q == $past(fr_in));

endmodule

// File: rtl/lcd_row_latch.sv
module lcd_row_latch
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COLS = 80,
  parameter int NUM_COMS = 16,
  parameter int LINE_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_tick,
  input  logic                disp_on,
  input  logic                static_drive,
  input  logic                seg_reverse,
  input  logic [NUM_COLS-1:0] row_data,
  input  logic [LINE_W-1:0]   next_line,
  output logic [NUM_COLS-1:0] seg_data,
  output logic [NUM_COMS-1:0] com_sel
);
  function automatic logic [NUM_COLS-1:0] mirror_row(input logic [NUM_COLS-1:0] row, input logic rev);
    logic [NUM_COLS-1:0] out;
    for (int i = 0; i < NUM_COLS; i++) out[i] = rev ? row[NUM_COLS-1-i] : row[i];
    return out;
  endfunction

  // Lines beyond the local commons decode to no select
  function automatic logic [NUM_COMS-1:0] com_decode(input logic [LINE_W-1:0] line);
    logic [NUM_COMS-1:0] out;
    for (int c = 0; c < NUM_COMS; c++) out[c] = (line == LINE_W'(c));
    return out;
  endfunction

  row_mode_e           mode;
  logic                dark;
  logic [NUM_COLS-1:0] seg_next;

  assign mode = pick_row_mode(disp_on, static_drive);
  assign dark = is_power_save(disp_on, static_drive);

  always_comb begin
    unique case (mode)
      ROW_BLANK: seg_next = '0;
      ROW_FULL:  seg_next = '1;
      default:   seg_next = mirror_row(row_data, seg_reverse);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_data <= '0;
      com_sel  <= '0;
    end else if (line_tick) begin
      seg_data <= seg_next;
      com_sel  <= dark ? '0 : com_decode(next_line);
    end
  end

  // R2: at most one common is active
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(com_sel));

  // R11: outputs move only on a line tick
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> $stable(seg_data) && $stable(com_sel));

  // R8: a power-save tick darkens commons and segments
  a_r8_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && !disp_on && static_drive) |=> (com_sel == '0) && (seg_data == '0));

endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COLS  = 80,
  parameter int NUM_COMS  = 16,
  parameter int NUM_LINES = 32,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_tick,
  input  logic                master,
  input  logic                fr_in,
  input  logic                disp_on,
  input  logic                static_drive,
  input  logic                duty_full,
  input  logic                seg_reverse,
  input  logic [LINE_W-1:0]   start_line,
  output logic [LINE_W-1:0]   ram_rd_addr,
  input  logic [NUM_COLS-1:0] ram_rd_data,
  output logic [NUM_COLS-1:0] seg_data,
  output logic [NUM_COMS-1:0] com_sel,
  output logic                fr_out,
  output logic                fr_oe,
  output logic                power_save
);
  logic [LINE_W-1:0] cur_line;
  logic [LINE_W-1:0] next_line;
  logic              wrap_evt;
  logic              resync;

  assign power_save  = is_power_save(disp_on, static_drive);
  assign ram_rd_addr = start_line + next_line;  // wraps modulo the RAM depth
  assign fr_oe       = master;

  lcd_line_ctr #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_tick (line_tick),
    .hold      (power_save),
    .duty_full (duty_full),
    .resync    (resync),
    .cur_line  (cur_line),
    .next_line (next_line),
    .wrap_evt  (wrap_evt)
  );

  lcd_frame_ac u_fr (
    .clk      (clk),
    .rst_n    (rst_n),
    .master   (master),
    .fr_in    (fr_in),
    .wrap_evt (wrap_evt),
    .fr_q     (fr_out),
    .resync   (resync)
  );

  lcd_row_latch #(.NUM_COLS(NUM_COLS), .NUM_COMS(NUM_COMS), .LINE_W(LINE_W)) u_latch (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_tick    (line_tick),
    .disp_on      (disp_on),
    .static_drive (static_drive),
    .seg_reverse  (seg_reverse),
    .row_data     (ram_rd_data),
    .next_line    (next_line),
    .seg_data     (seg_data),
    .com_sel      (com_sel)
  );

  // R9: a master FR change coincides with the scan sitting on line 0
  a_r9_fr_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (master && $past(master) && !$stable(fr_out)) |-> cur_line == '0);

  // R3: a line past the local commons leaves every common inactive
  a_r3_upper_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && (int'(next_line) >= NUM_COMS)) |=> com_sel == '0);

endmodule

// File: tb/test_lcd_scan_timing.sv
module test_lcd_scan_timing;
  localparam int COLS = 80;
  localparam int COMS = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            line_tick = 1'b0;
  logic            master = 1'b1;
  logic            fr_in = 1'b0;
  logic            disp_on = 1'b1;
  logic            static_drive = 1'b0;
  logic            duty_full = 1'b0;
  logic            seg_reverse = 1'b0;
  logic [4:0]      start_line = '0;
  logic [4:0]      ram_rd_addr;
  logic [COLS-1:0] ram_q = '0;
  logic [COLS-1:0] seg_data;
  logic [COMS-1:0] com_sel;
  logic            fr_out, fr_oe, power_save;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model of the scan
  int e_cur = 0;
  bit e_primed = 0;
  bit e_fr = 0;

  always #10ns clk = ~clk;

  lcd_scan_timing i_lcd_scan_timing (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .master(master), .fr_in(fr_in),
    .disp_on(disp_on), .static_drive(static_drive), .duty_full(duty_full),
    .seg_reverse(seg_reverse), .start_line(start_line), .ram_rd_addr(ram_rd_addr),
    .ram_rd_data(ram_q), .seg_data(seg_data), .com_sel(com_sel), .fr_out(fr_out),
    .fr_oe(fr_oe), .power_save(power_save)
  );

  // Contents of RAM line l, distinct for every line
  function automatic logic [COLS-1:0] ram_row(input int l);
    logic [COLS-1:0] r;
    for (int i = 0; i < COLS; i++) r[i] = (((i + 3 * l) % 7) == 0) ^ (i < l);
    return r;
  endfunction

  // synchronous-read RAM: one clock of latency
  always @(posedge clk) ram_q <= ram_row(int'(ram_rd_addr));

  task automatic chk(input bit ok, input string req, input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // One line tick plus a comparison against the bench model
  task automatic tick_check(input string req);
    logic [COLS-1:0] row, e_seg;
    logic [COMS-1:0] e_com;
    int lim, nl;
    lim = duty_full ? 32 : 16;
    if (!disp_on && static_drive) begin
      e_com = '0;
      e_seg = '0;
    end else begin
      nl = e_primed ? (e_cur + 1) % lim : 0;
      e_cur = nl;
      e_primed = 1;
      if (master && nl == 0) e_fr = ~e_fr;
      e_com = (nl < COMS) ? (COMS'(1) << nl) : '0;
      row = ram_row((int'(start_line) + nl) % 32);
      if (!disp_on)          e_seg = '0;
      else if (static_drive) e_seg = '1;
      else for (int i = 0; i < COLS; i++) e_seg[i] = seg_reverse ? row[COLS-1-i] : row[i];
    end
    line_tick = 1'b1;
    @(negedge clk);
    line_tick = 1'b0;
    chk(com_sel == e_com, {req, " com_sel"}, COLS'(com_sel), COLS'(e_com));
    chk(seg_data == e_seg, {req, " seg_data"}, seg_data, e_seg);
    if (master) chk(fr_out == e_fr, {req, " fr_out"}, COLS'(fr_out), COLS'(e_fr));
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(com_sel == '0 && seg_data == '0, "R1 outputs dark", COLS'(com_sel) | seg_data, '0);
    chk(fr_out == 1'b0, "R1 fr_out", COLS'(fr_out), '0);
    chk(fr_oe == 1'b1, "R9 fr_oe master", COLS'(fr_oe), COLS'(1));
    chk(power_save == 1'b0, "R8 no power save", COLS'(power_save), '0);
  endtask

  task automatic t_scan16();
    for (int k = 0; k < 18; k++) tick_check("R2 R4 R9 scan16");
  endtask

  task automatic t_offset_mirror();
    start_line = 5'd27;
    seg_reverse = 1'b1;
    settle();
    for (int k = 0; k < 8; k++) tick_check("R4 R5 offset mirror");
    seg_reverse = 1'b0;
    settle();
  endtask

  task automatic t_duty32();
    duty_full = 1'b1;
    start_line = 5'd3;
    settle();
    for (int k = 0; k < 36; k++) tick_check("R3 R2 duty32");
  endtask

  task automatic t_off_static();
    logic [COLS-1:0] held;
    disp_on = 1'b0;
    settle();
    tick_check("R6 blank");
    tick_check("R6 blank");
    held = seg_data;
    disp_on = 1'b1;
    repeat (3) @(negedge clk);
    chk(seg_data == held, "R11 no change without tick", seg_data, held);
    static_drive = 1'b1;
    settle();
    tick_check("R7 all on");
    tick_check("R7 all on");
    static_drive = 1'b0;
    settle();
  endtask

  task automatic t_power_save();
    disp_on = 1'b0;
    static_drive = 1'b1;
    settle();
    chk(power_save == 1'b1, "R8 flag", COLS'(power_save), COLS'(1));
    for (int k = 0; k < 3; k++) tick_check("R8 dark hold");
    disp_on = 1'b1;
    static_drive = 1'b0;
    settle();
    chk(power_save == 1'b0, "R8 flag clear", COLS'(power_save), '0);
    tick_check("R8 resume");
    tick_check("R8 resume");
  endtask

  task automatic t_slave();
    fr_in = e_fr;
    master = 1'b0;
    settle();
    chk(fr_oe == 1'b0, "R10 fr_oe slave", COLS'(fr_oe), '0);
    fr_in = ~fr_in;
    @(negedge clk);
    chk(fr_out == fr_in, "R10 fr follows", COLS'(fr_out), COLS'(fr_in));
    e_cur = 0;
    e_primed = 1;
    settle();
    tick_check("R10 realign");
    tick_check("R10 realign");
    chk(com_sel == 16'h0004, "R10 line two", COLS'(com_sel), COLS'(16'h0004));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scan16();
    t_offset_mirror();
    t_duty32();
    t_off_static();
    t_power_save();
    t_slave();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule